// File: doc/BRIEF.md
# Paged Address Translator with Access Protection

This unit turns a 16-bit virtual address into a 22-bit physical address. It keeps one set of eight page entries for each combination of run mode (four modes) and address space (instruction or data). The top three address bits pick the page. The page's base register, counted in 64-byte units, is scaled and added to the 13-bit offset. A control bit selects whether the sum is kept to 18 bits or to the full 22 bits. When a mode has data space turned off, its data accesses use that mode's instruction-space entries.

Each page also has a descriptor. The descriptor holds a 3-bit protection code, a 7-bit length, and a flag that says whether the page grows up or down. On every enabled access the unit checks the protection code, then whether the address hits installed memory, then the length. It reports any violation as an abort or a trap. The first fault logs its cause, mode, page and space in a status register, and that register stays frozen until software clears it. A faulting write also flags the page's descriptor.

The address output is combinational. The status register and the descriptor flag change on the clock edge of a faulting access. Software reads and writes every register through one small port.

Top module: `pg_xlate_unit`

## Requirements
- R1: With translation off (status bit 0 clear, and not a maintenance write), `physAddr` equals `accAddr` zero-extended and `faultType` is 0. `isIo` is 1 when that address is at or above 0xE000.
- R2: With translation on, `physAddr` = (base << 6) + `accAddr[12:0]`. The page is `accAddr[15:13]`, and the entry index is {mode, space, page}.
- R3: While extension bit 4 is clear, the sum is cut to 18 bits. With it set, all 22 bits are kept. `isIo` compares against 0x3E000 for 18 bits and 0x3FE000 for 22 bits.
- R4: A data access (`accData`=1) uses the data-space entries only when extension bit [mode] is set. Otherwise it uses the instruction-space entries of the same mode.
- R5: Descriptor bits 2:0 give the protection code, and `faultType` encodes 0=none, 1=abort, 2=trap. Codes 0, 3 and 7 abort every access. Code 1 traps reads and aborts writes. Code 2 aborts writes only. Code 4 traps every access. Code 5 traps writes only. Code 6 never faults.
- R6: Descriptor bits 14:8 are the length, and bit 3 set means the page grows down. A trap is raised when `accAddr[12:6]` is above the length on an up page, or below it on a down page. Equality passes.
- R7: A translated address at or above the installed size (1 MB by default) that is outside the I/O window aborts. An address inside the window does not.
- R8: On a logged fault the status register takes one cause bit and clears the other two. Bit 15 is set for non-resident (code 0 or 4, or missing memory), bit 14 for length, bit 13 for any other protection code. The register also takes the mode in bits 6:5, the space actually used in bit 4, and the page in bits 3:1. Bits 12:7 and bit 0 are kept.
- R9: While any of status bits 15:13 is set, faults leave the status register unchanged.
- R10: A faulting write sets descriptor bit 7 of the entry it used, whether or not the status register is frozen. A faulting read leaves bit 7 alone.
- R11: With status bit 8 set and bit 0 clear, writes are translated and checked, and reads are not.
- R12: Faults have a fixed priority: a protection-code fault first, then missing memory, then length.
- R13: With `accValid` low, `faultType` is 0 and neither the status register nor any descriptor changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access enable |
| accAddr | input | 16 | Virtual address |
| accMode | input | 2 | Run mode of the access |
| accData | input | 1 | 1 = data-space access |
| accWrite | input | 1 | 1 = write access |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 2 | 0 base, 1 descriptor, 2 status/control, 3 extension |
| cfgIdx | input | 6 | Entry index {mode, space, page} |
| cfgWrData | input | 16 | Register write data |
| cfgRdData | output | 16 | Register read data (combinational) |
| physAddr | output | 22 | Physical address |
| isIo | output | 1 | Address lies in the I/O window |
| faultType | output | 2 | 0 none, 1 abort, 2 trap |

## Verification
The hardest case to reach is one access that violates several rules at once, because only priority decides which fault is reported. Pages are set up with a failing protection code and a base beyond installed memory, or with a zero length and such a base. Status logging is also hard to see, because the first fault freezes the register. The stimulus therefore rewrites the status register before each logged fault and then sends a second fault to show that the freeze holds. Maintenance-mode writes are covered by turning translation off while leaving the maintenance bit set.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_ABORT = 2'd1,
    FLT_TRAP  = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_DESC = 2'd1,
    SEL_CSR  = 2'd2,
    SEL_EXT  = 2'd3
  } cfgsel_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic logFault;
    logic markTrap;
    logic nonRes;
    logic lenErr;
    logic roErr;
  } pgxStrobe_t;

  localparam int CSR_EN      = 0;
  localparam int CSR_MAINT   = 8;
  localparam int CSR_RO      = 13;
  localparam int CSR_LEN     = 14;
  localparam int CSR_NONRES  = 15;
  localparam int EXT_WIDE    = 4;
  localparam int DESC_DIR    = 3;
  localparam int DESC_TRAP   = 7;
  localparam int DESC_LEN_LO = 8;

endpackage

// File: rtl/pgx_datapath.sv
module pgx_datapath
  import pgx_pkg::*;
#(
  parameter int VA_W       = 16,
  parameter int PA_W       = 22,
  parameter int PA_NARROW  = 18,
  parameter int PAGE_BITS  = 3,
  parameter int MODE_W     = 2,
  parameter int BASE_SHIFT = 6,
  parameter int REG_W      = 16,
  parameter logic [PA_W-1:0] IO_OFF    = 22'h00E000,
  parameter logic [PA_W-1:0] IO_NARROW = 22'h03E000,
  parameter logic [PA_W-1:0] IO_WIDE   = 22'h3FE000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [VA_W-1:0]               accAddr,
  input  logic [MODE_W-1:0]             accMode,
  input  logic                          accData,
  input  logic                          accWrite,
  input  logic                          cfgWe,
  input  logic [1:0]                    cfgSel,
  input  logic [MODE_W+PAGE_BITS:0]     cfgIdx,
  input  logic [REG_W-1:0]              cfgWrData,
  output logic [REG_W-1:0]              cfgRdData,
  input  pgxStrobe_t                    stb,
  output logic [PA_W-1:0]               physAddr,
  output logic                          isIo,
  output logic                          xlatOn,
  output logic                          locked,
  output logic [2:0]                    accCode,
  output logic [VA_W-PAGE_BITS-BASE_SHIFT-1:0] lenLimit,
  output logic                          expandDown
);

  localparam int OFF_W   = VA_W - PAGE_BITS;
  localparam int IDX_W   = MODE_W + 1 + PAGE_BITS;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int LEN_W   = OFF_W - BASE_SHIFT;
  localparam logic [PA_W-1:0] NARROW_MASK = PA_W'((64'd1 << PA_NARROW) - 64'd1);

  logic [REG_W-1:0] baseTab [ENTRIES];
  logic [REG_W-1:0] descTab [ENTRIES];
  logic [REG_W-1:0] csrReg;
  logic [REG_W-1:0] extReg;

  logic             dSel;
  logic             wideOn;
  logic [IDX_W-1:0] accIdx;
  logic [REG_W-1:0] baseSel;
  logic [REG_W-1:0] descSel;
  logic [PA_W-1:0]  scaledBase;
  logic [PA_W-1:0]  sumFull;
  logic [PA_W-1:0]  sumKept;
  logic [PA_W-1:0]  ioBase;

  // Entry selection: data space only if enabled for this mode
  always_comb begin
    dSel    = accData & extReg[accMode];
    wideOn  = extReg[EXT_WIDE];
    accIdx  = {accMode, dSel, accAddr[VA_W-1:OFF_W]};
    baseSel = baseTab[accIdx];
    descSel = descTab[accIdx];
  end

  // Address arithmetic
  always_comb begin
    xlatOn     = csrReg[CSR_EN] | (accWrite & csrReg[CSR_MAINT]);
    scaledBase = PA_W'({baseSel, {BASE_SHIFT{1'b0}}});
    sumFull    = scaledBase + PA_W'(accAddr[OFF_W-1:0]);
    sumKept    = wideOn ? sumFull : (sumFull & NARROW_MASK);
    physAddr   = xlatOn ? sumKept : PA_W'(accAddr);
    if (!xlatOn)     ioBase = IO_OFF;
    else if (wideOn) ioBase = IO_WIDE;
    else             ioBase = IO_NARROW;
    isIo       = physAddr >= ioBase;
    locked     = |csrReg[CSR_NONRES:CSR_RO];
    accCode    = descSel[2:0];
    lenLimit   = descSel[DESC_LEN_LO +: LEN_W];
    expandDown = descSel[DESC_DIR];
  end

  // Register storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        baseTab[e] <= '0;
        descTab[e] <= '0;
      end
      csrReg <= '0;
      extReg <= '0;
    end else if (cfgWe) begin
      case (cfgSel)
        SEL_BASE: baseTab[cfgIdx] <= cfgWrData;
        SEL_DESC: descTab[cfgIdx] <= cfgWrData;
        SEL_CSR:  csrReg          <= cfgWrData;
        default:  extReg          <= cfgWrData;
      endcase
    end else begin
      if (stb.markTrap)
        descTab[accIdx][DESC_TRAP] <= 1'b1;
      if (stb.logFault)
        csrReg <= {stb.nonRes, stb.lenErr, stb.roErr,
                   csrReg[CSR_RO-1:7], accMode, dSel,
                   accAddr[VA_W-1:OFF_W], csrReg[CSR_EN]};
    end
  end

  // Readback
  always_comb begin
    case (cfgSel)
      SEL_BASE: cfgRdData = baseTab[cfgIdx];
      SEL_DESC: cfgRdData = descTab[cfgIdx];
      SEL_CSR:  cfgRdData = csrReg;
      default:  cfgRdData = extReg;
    endcase
  end

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !cfgWe) |=> $stable(csrReg)); // R9

  AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (xlatOn && !wideOn) |-> (physAddr[PA_W-1:PA_NARROW] == '0)); // R3

endmodule

// File: rtl/pgx_ctrl.sv
module pgx_ctrl
  import pgx_pkg::*;
#(
  parameter int PA_W  = 22,
  parameter int LEN_W = 7,
  parameter int MEM_BYTES = 32'h0010_0000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [LEN_W-1:0] lenBits,
  input  logic             xlatOn,
  input  logic             locked,
  input  logic [2:0]       accCode,
  input  logic [LEN_W-1:0] lenLimit,
  input  logic             expandDown,
  input  logic [PA_W-1:0]  physAddr,
  input  logic             isIo,
  output fault_e           faultType,
  output pgxStrobe_t       stb
);

  localparam logic [PA_W-1:0] MEM_TOP = PA_W'(MEM_BYTES);

  fault_e codeAct;
  logic   noMem;
  logic   lenBad;
  logic   active;
  logic   codeHit;

  // Protection-code decode
  always_comb begin
    codeAct = FLT_NONE;
    case (accCode)
      3'd1:    codeAct = accWrite ? FLT_ABORT : FLT_TRAP;
      3'd2:    codeAct = accWrite ? FLT_ABORT : FLT_NONE;
      3'd4:    codeAct = FLT_TRAP;
      3'd5:    codeAct = accWrite ? FLT_TRAP : FLT_NONE;
      3'd6:    codeAct = FLT_NONE;
      default: codeAct = FLT_ABORT;
    endcase
  end

  always_comb begin
    active  = accValid & xlatOn;
    noMem   = (physAddr >= MEM_TOP) & ~isIo;
    lenBad  = expandDown ? (lenBits < lenLimit) : (lenBits > lenLimit);
    codeHit = codeAct != FLT_NONE;

    faultType = FLT_NONE;
    stb       = '0;
    if (active) begin
      if (codeHit) begin
        faultType  = codeAct;
        stb.nonRes = (accCode == 3'd0) | (accCode == 3'd4);
        stb.roErr  = ~stb.nonRes;
      end else if (noMem) begin
        faultType  = FLT_ABORT;
        stb.nonRes = 1'b1;
      end else if (lenBad) begin
        faultType  = FLT_TRAP;
        stb.lenErr = 1'b1;
      end
    end
    stb.markTrap = (faultType != FLT_NONE) & accWrite;
    stb.logFault = (faultType != FLT_NONE) & ~locked;
  end

  AST_OFF_NO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !xlatOn) |-> (faultType == FLT_NONE)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (!stb.logFault && !stb.markTrap)); // R13

  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    stb.logFault |-> ($countones({stb.nonRes, stb.lenErr, stb.roErr}) == 1)); // R8

  AST_MARK_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    stb.markTrap |-> (accWrite && faultType != FLT_NONE)); // R10

endmodule

// File: rtl/pg_xlate_unit.sv
module pg_xlate_unit
  import pgx_pkg::*;
#(
  parameter int VA_W       = 16,
  parameter int PA_W       = 22,
  parameter int PA_NARROW  = 18,
  parameter int PAGE_BITS  = 3,
  parameter int MODE_W     = 2,
  parameter int BASE_SHIFT = 6,
  parameter int REG_W      = 16,
  parameter int MEM_BYTES  = 32'h0010_0000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      accValid,
  input  logic [VA_W-1:0]           accAddr,
  input  logic [MODE_W-1:0]         accMode,
  input  logic                      accData,
  input  logic                      accWrite,
  input  logic                      cfgWe,
  input  logic [1:0]                cfgSel,
  input  logic [MODE_W+PAGE_BITS:0] cfgIdx,
  input  logic [REG_W-1:0]          cfgWrData,
  output logic [REG_W-1:0]          cfgRdData,
  output logic [PA_W-1:0]           physAddr,
  output logic                      isIo,
  output logic [1:0]                faultType
);

  localparam int OFF_W = VA_W - PAGE_BITS;
  localparam int LEN_W = OFF_W - BASE_SHIFT;

  pgxStrobe_t       stb;
  fault_e           faultCode;
  logic             xlatOn;
  logic             locked;
  logic [2:0]       accCode;
  logic [LEN_W-1:0] lenLimit;
  logic             expandDown;

  pgx_datapath #(
    .VA_W(VA_W), .PA_W(PA_W), .PA_NARROW(PA_NARROW), .PAGE_BITS(PAGE_BITS),
    .MODE_W(MODE_W), .BASE_SHIFT(BASE_SHIFT), .REG_W(REG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .accAddr(accAddr), .accMode(accMode), .accData(accData), .accWrite(accWrite),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .stb(stb),
    .physAddr(physAddr), .isIo(isIo), .xlatOn(xlatOn), .locked(locked),
    .accCode(accCode), .lenLimit(lenLimit), .expandDown(expandDown)
  );

  pgx_ctrl #(
    .PA_W(PA_W), .LEN_W(LEN_W), .MEM_BYTES(MEM_BYTES)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .accValid(accValid), .accWrite(accWrite),
    .lenBits(accAddr[OFF_W-1:BASE_SHIFT]),
    .xlatOn(xlatOn), .locked(locked), .accCode(accCode),
    .lenLimit(lenLimit), .expandDown(expandDown),
    .physAddr(physAddr), .isIo(isIo),
    .faultType(faultCode), .stb(stb)
  );

  assign faultType = faultCode;

endmodule

// File: tb/pg_xlate_unit_tb.sv
`timescale 1ns/1ps
module pg_xlate_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [15:0] accAddr = '0;
  logic [1:0]  accMode = '0;
  logic        accData = 1'b0;
  logic        accWrite = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [5:0]  cfgIdx = '0;
  logic [15:0] cfgWrData = '0;
  logic [15:0] cfgRdData;
  logic [21:0] physAddr;
  logic        isIo;
  logic [1:0]  faultType;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pg_xlate_unit u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .accMode(accMode), .accData(accData), .accWrite(accWrite),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgIdx(cfgIdx), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .physAddr(physAddr), .isIo(isIo), .faultType(faultType)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] ext;
    logic [15:0] addr;
    logic [1:0]  mode;
    logic        dat;
    logic        wr;
    logic [21:0] phys;
    logic        io;
    logic [1:0]  flt;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  16'h0018, 16'h0010, 2'd0, 1'b0, 1'b0, 22'h004010, 1'b0, 2'd0}, // R2
    '{4'd2,  16'h0018, 16'h1FFE, 2'd0, 1'b0, 1'b0, 22'h005FFE, 1'b0, 2'd0}, // R2
    '{4'd5,  16'h0018, 16'h2004, 2'd0, 1'b0, 1'b0, 22'h008004, 1'b0, 2'd0}, // R5 code2 read
    '{4'd5,  16'h0018, 16'h2004, 2'd0, 1'b0, 1'b1, 22'h008004, 1'b0, 2'd1}, // R5 code2 write
    '{4'd5,  16'h0018, 16'h4000, 2'd0, 1'b0, 1'b0, 22'h000000, 1'b0, 2'd1}, // R5 code0
    '{4'd5,  16'h0018, 16'h6000, 2'd0, 1'b0, 1'b0, 22'h00C000, 1'b0, 2'd2}, // R5 code1 read
    '{4'd5,  16'h0018, 16'h6000, 2'd0, 1'b0, 1'b1, 22'h00C000, 1'b0, 2'd1}, // R5 code1 write
    '{4'd5,  16'h0018, 16'h8000, 2'd0, 1'b0, 1'b0, 22'h010000, 1'b0, 2'd2}, // R5 code4
    '{4'd5,  16'h0018, 16'hA000, 2'd0, 1'b0, 1'b0, 22'h014000, 1'b0, 2'd0}, // R5 code5 read
    '{4'd5,  16'h0018, 16'hA000, 2'd0, 1'b0, 1'b1, 22'h014000, 1'b0, 2'd2}, // R5 code5 write
    '{4'd5,  16'h0018, 16'h0000, 2'd1, 1'b0, 1'b0, 22'h000000, 1'b0, 2'd1}, // R5 code3
    '{4'd5,  16'h0018, 16'h2000, 2'd1, 1'b0, 1'b0, 22'h000000, 1'b0, 2'd1}, // R5 code7
    '{4'd3,  16'h0008, 16'hC100, 2'd0, 1'b0, 1'b0, 22'h0000C0, 1'b0, 2'd0}, // R3 narrow
    '{4'd3,  16'h0018, 16'hC100, 2'd0, 1'b0, 1'b0, 22'h0400C0, 1'b0, 2'd0}, // R3 wide
    '{4'd6,  16'h0018, 16'hE800, 2'd0, 1'b0, 1'b0, 22'h3FE800, 1'b1, 2'd0}, // R6 down, equal
    '{4'd6,  16'h0018, 16'hE7C0, 2'd0, 1'b0, 1'b0, 22'h3FE7C0, 1'b1, 2'd2}, // R6 down, below
    '{4'd3,  16'h0008, 16'hE800, 2'd0, 1'b0, 1'b0, 22'h03E800, 1'b1, 2'd0}, // R3 narrow io
    '{4'd7,  16'h0018, 16'h4000, 2'd1, 1'b0, 1'b0, 22'h200000, 1'b0, 2'd1}, // R7 no memory
    '{4'd7,  16'h0008, 16'h4000, 2'd1, 1'b0, 1'b0, 22'h000000, 1'b0, 2'd0}, // R7 wraps in 18 bits
    '{4'd12, 16'h0018, 16'h6000, 2'd1, 1'b0, 1'b0, 22'h200000, 1'b0, 2'd2}, // R12 code beats no-mem
    '{4'd12, 16'h0018, 16'h8040, 2'd1, 1'b0, 1'b0, 22'h200040, 1'b0, 2'd1}, // R12 no-mem beats length
    '{4'd6,  16'h0018, 16'hA440, 2'd1, 1'b0, 1'b0, 22'h004440, 1'b0, 2'd2}, // R6 up, above
    '{4'd6,  16'h0018, 16'hA400, 2'd1, 1'b0, 1'b0, 22'h004400, 1'b0, 2'd0}, // R6 up, equal
    '{4'd4,  16'h0018, 16'h0020, 2'd3, 1'b1, 1'b0, 22'h018020, 1'b0, 2'd0}, // R4 data space
    '{4'd4,  16'h0018, 16'h0020, 2'd3, 1'b0, 1'b0, 22'h010020, 1'b0, 2'd0}, // R4 instr space
    '{4'd4,  16'h0018, 16'h0020, 2'd0, 1'b1, 1'b0, 22'h004020, 1'b0, 2'd0}  // R4 fallback
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [5:0] idx, input logic [15:0] d);
    @(negedge clk);
    accValid  = 1'b0;
    cfgWe     = 1'b1;
    cfgSel    = sel;
    cfgIdx    = idx;
    cfgWrData = d;
    @(negedge clk);
    cfgWe     = 1'b0;
  endtask

  task automatic cfgRead(input logic [1:0] sel, input logic [5:0] idx, output logic [15:0] d);
    @(negedge clk);
    accValid = 1'b0;
    cfgWe    = 1'b0;
    cfgSel   = sel;
    cfgIdx   = idx;
    #1;
    d = cfgRdData;
  endtask

  task automatic access(input logic v, input logic [15:0] a, input logic [1:0] m,
                        input logic dt, input logic w);
    @(negedge clk);
    cfgWe    = 1'b0;
    accValid = v;
    accAddr  = a;
    accMode  = m;
    accData  = dt;
    accWrite = w;
    #1;
  endtask

  task automatic page(input logic [5:0] idx, input logic [15:0] b, input logic [15:0] d);
    cfgWrite(2'd0, idx, b);
    cfgWrite(2'd1, idx, d);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state (R1)
    cfgRead(2'd2, 6'd0, rd);
    chk("R1 reset status", rd, 16'h0000);
    access(1'b0, 16'h1234, 2'd0, 1'b0, 1'b0);
    chk("R1 reset phys", physAddr, 22'h001234);
    chk("R1 reset fault", faultType, 2'd0);
    chk("R1 reset io", isIo, 1'b0);

    // Page tables
    page(6'h00, 16'h0100, 16'h7F06);
    page(6'h01, 16'h0200, 16'h7F02);
    page(6'h02, 16'h0000, 16'h7F00);
    page(6'h03, 16'h0300, 16'h7F01);
    page(6'h04, 16'h0400, 16'h7F04);
    page(6'h05, 16'h0500, 16'h7F05);
    page(6'h06, 16'h0FFF, 16'h1006);
    page(6'h07, 16'hFF80, 16'h200E);
    page(6'h08, 16'h0700, 16'h7F06);
    page(6'h10, 16'h0000, 16'h7F03);
    page(6'h11, 16'h0000, 16'h7F07);
    page(6'h12, 16'h8000, 16'h7F06);
    page(6'h13, 16'h8000, 16'h7F04);
    page(6'h14, 16'h8000, 16'h0006);
    page(6'h15, 16'h0100, 16'h1006);
    page(6'h30, 16'h0400, 16'h7F06);
    page(6'h38, 16'h0600, 16'h7F06);
    page(6'h39, 16'h0000, 16'h7F04);
    cfgWrite(2'd2, 6'd0, 16'h0001);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      cfgWrite(2'd3, 6'd0, VEC[i].ext);
      access(1'b1, VEC[i].addr, VEC[i].mode, VEC[i].dat, VEC[i].wr);
      chk({tag, " phys"}, physAddr, VEC[i].phys);
      chk({tag, " io"}, isIo, VEC[i].io);
      chk({tag, " fault"}, faultType, VEC[i].flt);
    end

    // R10: trapped flag only after faulting writes
    cfgRead(2'd1, 6'h01, rd); chk("R10 code2 write marks", rd, 16'h7F82);
    cfgRead(2'd1, 6'h03, rd); chk("R10 code1 write marks", rd, 16'h7F81);
    cfgRead(2'd1, 6'h04, rd); chk("R10 read fault no mark", rd, 16'h7F04);
    cfgRead(2'd1, 6'h05, rd); chk("R10 code5 write marks", rd, 16'h7F85);
    cfgRead(2'd1, 6'h00, rd); chk("R10 good write no mark", rd, 16'h7F06);

    // R8 / R9: status logging and freeze
    cfgWrite(2'd3, 6'd0, 16'h0018);
    cfgWrite(2'd2, 6'd0, 16'h0001);
    access(1'b1, 16'h0000, 2'd1, 1'b0, 1'b0);
    cfgRead(2'd2, 6'd0, rd); chk("R8 read-only cause", rd, 16'h2021);
    access(1'b1, 16'h4000, 2'd0, 1'b0, 1'b0);
    chk("R9 second fault seen", faultType, 2'd1);
    cfgRead(2'd2, 6'd0, rd); chk("R9 status frozen", rd, 16'h2021);

    cfgWrite(2'd2, 6'd0, 16'h0001);
    access(1'b1, 16'h2000, 2'd3, 1'b1, 1'b0);
    chk("R8 data-space trap", faultType, 2'd2);
    cfgRead(2'd2, 6'd0, rd); chk("R8 non-resident data", rd, 16'h8073);

    cfgWrite(2'd2, 6'd0, 16'h0001);
    access(1'b1, 16'hA440, 2'd1, 1'b0, 1'b0);
    cfgRead(2'd2, 6'd0, rd); chk("R8 length cause", rd, 16'h402B);

    cfgWrite(2'd2, 6'd0, 16'h0001);
    access(1'b1, 16'h4000, 2'd1, 1'b0, 1'b0);
    cfgRead(2'd2, 6'd0, rd); chk("R7 missing memory logs", rd, 16'h8025);

    // R11: maintenance bit translates writes only
    cfgWrite(2'd2, 6'd0, 16'h0100);
    access(1'b1, 16'h2004, 2'd0, 1'b0, 1'b0);
    chk("R11 read untranslated", physAddr, 22'h002004);
    chk("R11 read no fault", faultType, 2'd0);
    access(1'b1, 16'h2004, 2'd0, 1'b0, 1'b1);
    chk("R11 write translated", physAddr, 22'h008004);
    chk("R11 write checked", faultType, 2'd1);
    cfgRead(2'd2, 6'd0, rd); chk("R11 write logged", rd, 16'h2102);

    // R1: translation off
    cfgWrite(2'd2, 6'd0, 16'h0000);
    access(1'b1, 16'hE010, 2'd0, 1'b0, 1'b0);
    chk("R1 off phys", physAddr, 22'h00E010);
    chk("R1 off io", isIo, 1'b1);
    chk("R1 off fault", faultType, 2'd0);
    access(1'b1, 16'h4000, 2'd0, 1'b0, 1'b1);
    chk("R1 off write phys", physAddr, 22'h004000);
    chk("R1 off write fault", faultType, 2'd0);
    chk("R1 off low io", isIo, 1'b0);

    // R13: idle access has no effect
    cfgWrite(2'd2, 6'd0, 16'h0001);
    access(1'b0, 16'h4000, 2'd0, 1'b0, 1'b1);
    chk("R13 idle fault", faultType, 2'd0);
    cfgRead(2'd2, 6'd0, rd); chk("R13 idle status", rd, 16'h0001);
    cfgRead(2'd1, 6'h02, rd); chk("R13 idle descriptor", rd, 16'h7F00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule